// File: doc/BRIEF.md
# Priority Transmit Scheduler

This block decides which CAN frame goes out next. The host queues ordinary frames in a circular transmit queue. It can also park one urgent frame in a single high-priority slot. Each frame carries an identifier, the extended-format and remote-request bits, a length code and up to eight data bytes.

Whenever the bus is idle and no attempt is running, the scheduler picks a frame and holds it on the serialiser interface with a request level. The priority slot, if occupied, is picked ahead of the queue head. The serialiser returns exactly one result per attempt: success, lost arbitration, or transmit error. Only a success releases the frame. The other two results leave the frame in place, so it is tried again at the next idle point.

Three sticky event bits record priority-frame completion, queue-frame completion and queue overflow. A mask selects which of them drive the interrupt line.

Top module: `can_tx_sched`

## Requirements
- R1: Frames written through `fifoWrEn` leave the queue in the order they were written. The queue depth `FIFO_DEPTH` is a parameter with legal values 2 to 63.
- R2: After reset, `fifoEmpty`=1, `fifoFull`=0, `prioBusy`=0, `txReq`=0, `irqFlags`=0 and `irq`=0. `fifoFull` is 1 exactly when `FIFO_DEPTH` frames are queued, and `fifoEmpty` is 1 exactly when none are.
- R3: A queue write while `fifoFull`=1 is discarded, so the frame is never transmitted. The same write sets `irqFlags[2]` (overflow) at the next clock edge.
- R4: The priority slot holds one frame, and `prioBusy` shows that it is occupied. A `prioWrEn` write while the slot is occupied is discarded.
- R5: A new attempt starts only at a clock edge where `busIdle`=1 and no attempt is running. At that edge the priority slot is chosen if it is occupied, and otherwise the queue head is chosen. `txReq` goes high after that edge.
- R6: While `txReq` is high, the presented frame stays unchanged until a result arrives. A priority write during a queue-frame attempt waits for the next selection point.
- R7: When `txArbLost` or `txErr` arrives while `txReq` is high, `txReq` drops after the edge and the frame stays stored. The frame is selected again at the next idle point, and an occupied priority slot may overtake it there.
- R8: A frame is released only by `txOk` while `txReq`=1. Result inputs seen while `txReq`=0 have no effect.
- R9: `irqFlags` bit 0 sets when a priority frame completes, and bit 1 sets when a queue frame completes. The bits are sticky. Each is cleared by a 1 on the matching `flagClr` bit, but a set in the same cycle takes precedence over the clear.
- R10: `irq` is high exactly when some `irqFlags` bit is 1 and its matching `irqMask` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifoWrEn | input | 1 | Queue a frame from the write fields |
| prioWrEn | input | 1 | Load the priority slot from the write fields |
| wrId | input | 29 | Identifier of the written frame |
| wrExt | input | 1 | Extended-identifier bit of the written frame |
| wrRtr | input | 1 | Remote-request bit of the written frame |
| wrDlc | input | 4 | Length code of the written frame |
| wrData | input | 64 | Data bytes of the written frame |
| busIdle | input | 1 | Serialiser reports the bus is idle |
| txOk | input | 1 | Attempt completed successfully |
| txArbLost | input | 1 | Attempt lost arbitration |
| txErr | input | 1 | Attempt ended with a transmit error |
| txReq | output | 1 | Attempt in progress, frame fields valid |
| txId | output | 29 | Identifier of the presented frame |
| txExt | output | 1 | Extended-identifier bit of the presented frame |
| txRtr | output | 1 | Remote-request bit of the presented frame |
| txDlc | output | 4 | Length code of the presented frame |
| txData | output | 64 | Data bytes of the presented frame |
| fifoFull | output | 1 | Queue holds FIFO_DEPTH frames |
| fifoEmpty | output | 1 | Queue holds no frame |
| prioBusy | output | 1 | Priority slot occupied |
| flagClr | input | 3 | Write-one-to-clear for irqFlags |
| irqMask | input | 3 | Interrupt enable per event bit |
| irqFlags | output | 3 | Sticky events: 0 priority done, 1 queue done, 2 overflow |
| irq | output | 1 | Interrupt request |

## Verification
The assertions rely on the serialiser driving at most one of `txOk`, `txArbLost` and `txErr` in a cycle, and only while `txReq` is high. They also rely on the host not clearing a flag in the same cycle an assertion expects it set. The bench keeps each result to a one-cycle pulse issued only after it has seen `txReq` high. The one deliberate exception is a `txOk` pulse while idle, used to show that such a pulse is ignored. During that exception the queue is held idle so that no release strobe can occur. Flags are cleared only between scenarios.

// File: rtl/txsched_pkg.sv
package txsched_pkg;
  localparam int ID_W   = 29;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              ext;
    logic              rtr;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } txFrame_t;

  // strobes from control to datapath
  typedef struct packed {
    logic selPrio;   // present the priority slot rather than the queue head
    logic popFifo;   // release queue head
    logic freePrio;  // release priority slot
  } schedStrobe_t;

  typedef enum logic {S_IDLE, S_BUSY} schedState_t;
endpackage

// File: rtl/txsched_ctrl.sv
module txsched_ctrl
  import txsched_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         busIdle,
  input  logic         fifoEmpty,
  input  logic         prioValid,
  input  logic         txOk,
  input  logic         txArbLost,
  input  logic         txErr,
  output schedStrobe_t strb,
  output logic         txReq
);
  schedState_t state;
  logic        curPrio;
  logic        launch, success, failed;

  always_comb begin
    launch  = (state == S_IDLE) && busIdle && (prioValid || !fifoEmpty);
    success = (state == S_BUSY) && txOk;
    failed  = (state == S_BUSY) && !txOk && (txArbLost || txErr);
    strb.selPrio  = (state == S_BUSY) ? curPrio : prioValid;
    strb.popFifo  = success && !curPrio;
    strb.freePrio = success && curPrio;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      curPrio <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (launch) begin
          state   <= S_BUSY;
          curPrio <= prioValid;
        end
        S_BUSY: if (success || failed) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign txReq = (state == S_BUSY);
endmodule

// File: rtl/txsched_dp.sv
module txsched_dp
  import txsched_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fifoWrEn,
  input  logic         prioWrEn,
  input  txFrame_t     wrFrame,
  input  schedStrobe_t strb,
  input  logic [2:0]   flagClr,
  input  logic [2:0]   irqMask,
  output txFrame_t     txFrame,
  output logic         fifoFull,
  output logic         fifoEmpty,
  output logic         prioValid,
  output logic [2:0]   irqFlags,
  output logic         irq
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  txFrame_t         mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  txFrame_t         prioFrame;
  logic             push, ovfHit;
  logic [2:0]       setVec;

  assign fifoFull  = (count == CNT_W'(DEPTH));
  assign fifoEmpty = (count == '0);
  assign push      = fifoWrEn && !fifoFull;
  assign ovfHit    = fifoWrEn && fifoFull;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrFrame;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push)         wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + PTR_W'(1);
      if (strb.popFifo) rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + PTR_W'(1);
      if (push && !strb.popFifo)      count <= count + CNT_W'(1);
      else if (!push && strb.popFifo) count <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prioValid <= 1'b0;
      prioFrame <= '0;
    end else if (strb.freePrio) begin
      prioValid <= 1'b0;
    end else if (prioWrEn && !prioValid) begin
      prioValid <= 1'b1;
      prioFrame <= wrFrame;
    end
  end

  assign txFrame = strb.selPrio ? prioFrame : mem[rdPtr];

  assign setVec = {ovfHit, strb.popFifo, strb.freePrio};

  for (genvar g = 0; g < 3; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)            irqFlags[g] <= 1'b0;
      else if (setVec[g]) irqFlags[g] <= 1'b1;
      else if (flagClr[g]) irqFlags[g] <= 1'b0;
    end
  end

  assign irq = |(irqFlags & irqMask);
endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
  import txsched_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        fifoWrEn,
  input  logic        prioWrEn,
  input  logic [28:0] wrId,
  input  logic        wrExt,
  input  logic        wrRtr,
  input  logic [3:0]  wrDlc,
  input  logic [63:0] wrData,
  input  logic        busIdle,
  input  logic        txOk,
  input  logic        txArbLost,
  input  logic        txErr,
  output logic        txReq,
  output logic [28:0] txId,
  output logic        txExt,
  output logic        txRtr,
  output logic [3:0]  txDlc,
  output logic [63:0] txData,
  output logic        fifoFull,
  output logic        fifoEmpty,
  output logic        prioBusy,
  input  logic [2:0]  flagClr,
  input  logic [2:0]  irqMask,
  output logic [2:0]  irqFlags,
  output logic        irq
);
  schedStrobe_t strb;
  txFrame_t     wrFrame, txFrame;

  assign wrFrame = '{id: wrId, ext: wrExt, rtr: wrRtr, dlc: wrDlc, data: wrData};

  txsched_ctrl u_ctrl (
    .clk(clk), .rst(rst), .busIdle(busIdle), .fifoEmpty(fifoEmpty),
    .prioValid(prioBusy), .txOk(txOk), .txArbLost(txArbLost), .txErr(txErr),
    .strb(strb), .txReq(txReq)
  );

  txsched_dp #(.DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rst(rst), .fifoWrEn(fifoWrEn), .prioWrEn(prioWrEn),
    .wrFrame(wrFrame), .strb(strb), .flagClr(flagClr), .irqMask(irqMask),
    .txFrame(txFrame), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .prioValid(prioBusy), .irqFlags(irqFlags), .irq(irq)
  );

  assign txId   = txFrame.id;
  assign txExt  = txFrame.ext;
  assign txRtr  = txFrame.rtr;
  assign txDlc  = txFrame.dlc;
  assign txData = txFrame.data;
endmodule

// File: rtl/txsched_chk.sv
module txsched_chk #(
  parameter int DEPTH = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        busIdle,
  input logic        txReq,
  input logic        txOk,
  input logic        txArbLost,
  input logic        txErr,
  input logic [28:0] txId,
  input logic [63:0] txData,
  input logic        fifoWrEn,
  input logic        fifoFull,
  input logic        fifoEmpty,
  input logic        prioBusy,
  input logic [2:0]  irqFlags,
  input logic        selPrio,
  input logic        popFifo,
  input logic        freePrio
);
  initial begin
    a_depth_r1: assert (DEPTH >= 2 && DEPTH <= 63);
  end

  p_stable_frame_r6: assert property (@(posedge clk) disable iff (rst)
    txReq && !(txOk || txArbLost || txErr) |=>
      txReq && $stable(txId) && $stable(txData) && $stable(selPrio));

  p_launch_idle_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(txReq) |-> $past(busIdle));

  p_prio_first_r5: assert property (@(posedge clk) disable iff (rst)
    !txReq && busIdle && prioBusy |=> txReq && selPrio);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    fifoWrEn && fifoFull |=> irqFlags[2]);

  p_retry_keep_r7: assert property (@(posedge clk) disable iff (rst)
    txReq && selPrio && !txOk && (txArbLost || txErr) |=> prioBusy && !txReq);

  p_pop_legal_r8: assert property (@(posedge clk) disable iff (rst)
    popFifo |-> txReq && txOk && !fifoEmpty);

  p_free_on_ok_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(prioBusy) |-> $past(txOk && txReq && selPrio));

  p_done_flag_r9: assert property (@(posedge clk) disable iff (rst)
    freePrio |=> irqFlags[0]);
endmodule

bind can_tx_sched txsched_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .busIdle(busIdle), .txReq(txReq), .txOk(txOk),
  .txArbLost(txArbLost), .txErr(txErr), .txId(txId), .txData(txData),
  .fifoWrEn(fifoWrEn), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
  .prioBusy(prioBusy), .irqFlags(irqFlags), .selPrio(strb.selPrio),
  .popFifo(strb.popFifo), .freePrio(strb.freePrio)
);

// File: tb/tb_can_tx_sched.sv
module tb_can_tx_sched;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic fifoWrEn = 0, prioWrEn = 0, wrExt = 0, wrRtr = 0;
  logic [28:0] wrId = '0;
  logic [3:0]  wrDlc = '0;
  logic [63:0] wrData = '0;
  logic busIdle = 0, txOk = 0, txArbLost = 0, txErr = 0;
  logic [2:0] flagClr = '0, irqMask = '0;
  logic txReq, txExt, txRtr, fifoFull, fifoEmpty, prioBusy, irq;
  logic [28:0] txId;
  logic [3:0]  txDlc;
  logic [63:0] txData;
  logic [2:0]  irqFlags;

  int nRun = 0, nFail = 0;

  always #2.5 clk = ~clk;

  can_tx_sched #(.FIFO_DEPTH(DEPTH)) dut (.*);

  task automatic chk(input logic cond, input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!cond) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrFifo(input logic [28:0] id);
    fifoWrEn = 1; wrId = id; wrData = {35'd0, id}; wrDlc = 4'd8;
    @(negedge clk); fifoWrEn = 0;
  endtask

  task automatic wrPrio(input logic [28:0] id);
    prioWrEn = 1; wrId = id; wrData = {35'd0, id}; wrDlc = 4'd8;
    @(negedge clk); prioWrEn = 0;
  endtask

  // kind: 0 ok, 1 arbitration lost, 2 error
  task automatic result(input int kind);
    txOk = (kind == 0); txArbLost = (kind == 1); txErr = (kind == 2);
    @(negedge clk); txOk = 0; txArbLost = 0; txErr = 0;
  endtask

  task automatic waitTx(input logic [28:0] exp, input string req);
    for (int n = 0; n < 10 && !txReq; n++) @(negedge clk);
    chk(txReq && txId == exp && txData == {35'd0, exp}, req, txId, exp);
  endtask

  task automatic clearFlags();
    flagClr = 3'b111; @(negedge clk); flagClr = '0;
  endtask

  task automatic t_reset();
    chk(fifoEmpty && !fifoFull && !prioBusy && !txReq, "R2 reset status",
        {fifoEmpty, fifoFull, prioBusy, txReq}, 4'b1000);
    chk(irqFlags == 0 && !irq, "R2 reset flags", {irqFlags, irq}, 0);
  endtask

  task automatic t_order();
    busIdle = 0;
    wrFifo(1); wrFifo(2); wrFifo(3);
    @(negedge clk);
    chk(!txReq, "R5 no launch while bus busy", txReq, 0);
    busIdle = 1;
    @(negedge clk);
    chk(txReq, "R5 launch one cycle after idle", txReq, 1);
    for (int i = 1; i <= 3; i++) begin
      waitTx(29'(i), "R1 queue order");
      result(0);
    end
    chk(fifoEmpty && irqFlags[1], "R9 queue done flag", {fifoEmpty, irqFlags[1]}, 2'b11);
    clearFlags();
  endtask

  task automatic t_full();
    busIdle = 0;
    for (int i = 0; i < DEPTH; i++) wrFifo(29'(100 + i));
    chk(fifoFull && !fifoEmpty, "R2 full at depth", {fifoFull, fifoEmpty}, 2'b10);
    wrFifo(29'h1FF);
    chk(irqFlags[2], "R3 overflow flag", irqFlags, 3'b100);
    busIdle = 1;
    for (int i = 0; i < DEPTH; i++) begin
      waitTx(29'(100 + i), "R3 queued frames intact");
      result(0);
    end
    @(negedge clk); @(negedge clk);
    chk(!txReq && fifoEmpty, "R3 dropped write never sent", {txReq, fifoEmpty}, 2'b01);
    clearFlags();
  endtask

  task automatic t_prio();
    busIdle = 0;
    wrFifo(10); wrPrio(20); wrPrio(21);
    chk(prioBusy, "R4 slot occupied", prioBusy, 1);
    busIdle = 1;
    waitTx(20, "R5 priority before queue");
    result(0);
    chk(!prioBusy && irqFlags[0], "R9 priority done flag", {prioBusy, irqFlags[0]}, 2'b01);
    waitTx(10, "R4 second priority write discarded");
    result(0);
    @(negedge clk); @(negedge clk);
    chk(!txReq && !prioBusy, "R4 nothing left", {txReq, prioBusy}, 0);
    clearFlags();
  endtask

  task automatic t_nopreempt();
    busIdle = 1;
    wrFifo(30);
    waitTx(30, "R6 queue frame started");
    wrPrio(40);
    @(negedge clk);
    chk(txReq && txId == 30, "R6 no pre-emption", txId, 30);
    result(0);
    waitTx(40, "R6 priority follows");
    result(0);
    clearFlags();
  endtask

  task automatic t_retry();
    busIdle = 1;
    wrFifo(50);
    waitTx(50, "R7 first attempt");
    busIdle = 0;
    result(1);
    chk(!txReq && !fifoEmpty, "R7 arbitration loss keeps frame", {txReq, fifoEmpty}, 0);
    busIdle = 1;
    waitTx(50, "R7 retry after arbitration loss");
    busIdle = 0;
    result(2);
    chk(!txReq && !fifoEmpty && irqFlags == 0, "R7 error keeps frame", {txReq, fifoEmpty, irqFlags}, 0);
    wrPrio(60);
    busIdle = 1;
    waitTx(60, "R7 priority overtakes retry");
    result(0);
    waitTx(50, "R7 retried frame completes");
    result(0);
    chk(fifoEmpty && !prioBusy, "R7 both released", {fifoEmpty, prioBusy}, 2'b10);
    clearFlags();
  endtask

  task automatic t_ignored();
    busIdle = 0;
    wrFifo(70);
    result(0);
    chk(!fifoEmpty && irqFlags == 0, "R8 result while idle ignored", {fifoEmpty, irqFlags}, 0);
    busIdle = 1;
    waitTx(70, "R8 frame still sent");
    result(0);
  endtask

  task automatic t_irq();
    irqMask = 3'b000;
    @(negedge clk);
    chk(irqFlags == 3'b010 && !irq, "R10 masked", {irqFlags, irq}, 4'b0100);
    irqMask = 3'b010;
    @(negedge clk);
    chk(irq, "R10 enabled source", irq, 1);
    irqMask = 3'b101;
    @(negedge clk);
    chk(!irq, "R10 other bits masked", irq, 0);
    clearFlags();
    irqMask = 3'b111;
    @(negedge clk);
    chk(irqFlags == 0 && !irq, "R9 write-one-to-clear", {irqFlags, irq}, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_order();
    t_full();
    t_prio();
    t_nopreempt();
    t_retry();
    t_ignored();
    t_irq();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule